// File: doc/BRIEF.md
# Transport Stream Output Formatter

This block sits at the end of a cable receive chain. It takes decoded transport packets one byte at a time and drives them onto the chip's output pins. Each packet is 188 bytes long. Its first byte carries a start marker, and the packet as a whole carries a flag that says whether the decoder could correct it. A mode input chooses how bytes leave the block. In parallel mode each byte appears on an 8-bit bus for one cycle. In serial mode each byte is shifted out most significant bit first on bit 0 of the bus, and every bit is held for `BIT_CYCLES` clock cycles.

Along with the data, the block produces:
- a data-valid level;
- a clock-enable strobe that marks each new byte or bit;
- a packet-start pulse;
- a level that marks packets the decoder could not correct.

The start byte always leaves the block as 0x47, even when it arrived in its inverted form. For a flagged packet, the block sets the most significant bit of the byte that follows the start byte, so that downstream equipment sees the error. Two inhibit inputs can each suppress that marking. While a serial byte is being shifted out, a ready output pushes back on the upstream source.

Top module: `ts_out_fmt`

## Requirements
- R1: After reset, `ts_den`, `ts_clk_en`, `ts_sync` and `ts_uncor` are low and `in_ready` is high.
- R2: In parallel mode (`ser_mode`=0), a byte accepted on a clock edge (`in_valid` and `in_ready` both high) appears on `ts_data` in the following cycle. `ts_den` and `ts_clk_en` are high for exactly that one cycle. Both are low in any cycle that follows an edge with no accepted byte.
- R3: A byte accepted with `in_start`=1 is output as 0x47, whether its input value is 0x47 or 0xB8.
- R4: In parallel mode, `ts_sync` is high during the cycle that presents the start byte and is low in every other cycle.
- R5: `ts_uncor` takes the `in_uncor` value that came with a packet's start byte. It shows that value from the presentation of the start byte through all 188 bytes, including idle gaps, until the next start byte is presented.
- R6: For a packet flagged uncorrectable, byte 1 of the packet (the byte right after the start byte) is output with bit 7 set to 1, but only when `inh_rs` and `inh_tei` are both 0. If either inhibit is 1, or if the packet is not flagged, byte 1 passes unchanged. Bytes 2 to 187 always pass unchanged.
- R7: In serial mode (`ser_mode`=1), an accepted byte is sent on `ts_data[0]` most significant bit first, each bit held for `BIT_CYCLES` cycles, starting the cycle after acceptance. `ts_data[7:1]` is 0 and `ts_den` is high for all 8·`BIT_CYCLES` cycles.
- R8: In serial mode, `ts_clk_en` is high only in the first cycle of each bit. It is never high while `ts_den` is low.
- R9: In serial mode, `ts_sync` is high only during the first bit of the start byte.
- R10: `in_ready` is low while a serial byte is being shifted out, except in its final cycle. A byte offered in that final cycle is accepted, and its first bit follows the last bit of the previous byte with no gap.
- R11: In parallel mode with no serial byte in flight, `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_mode | input | 1 | 0 = parallel output, 1 = serial output |
| inh_rs | input | 1 | Suppresses the header error marking when 1 |
| inh_tei | input | 1 | Suppresses the header error marking when 1 |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept a byte this cycle |
| in_data | input | 8 | Input byte |
| in_start | input | 1 | Input byte is the first byte of a packet |
| in_uncor | input | 1 | Packet is uncorrectable (sampled with the start byte) |
| ts_data | output | 8 | Output bus; serial data on bit 0 |
| ts_den | output | 1 | Output carries valid data |
| ts_clk_en | output | 1 | Strobe marking each new output byte or bit |
| ts_sync | output | 1 | Packet start pulse |
| ts_uncor | output | 1 | Current packet is uncorrectable |

## Verification
Parallel packets are sent four ways:
- a clean packet with a true start byte;
- a flagged packet with an inverted start byte and both inhibits low;
- a flagged packet with `inh_rs` high;
- a flagged packet with `inh_tei` high.

Comparing these separates start-byte restoration from header marking, and shows that each inhibit acts on its own. A clean packet sent after the flagged ones shows that the uncorrectable level follows the start byte rather than sticking. Mid-packet idle gaps show that data-valid and sync drop when there is no byte while the packet flag holds. A serial run sends four back-to-back bytes, including the inverted start and the marked header byte, and checks every bit cycle for bit order, strobe placement, the one-bit sync and ready back-pressure.

// File: rtl/ts_fmt_pkg.sv
package ts_fmt_pkg;

    localparam logic [7:0] SYNC_BYTE = 8'h47;

    // One formatted byte travelling from the packet tracker to an output stage
    typedef struct packed {
        logic [7:0] data;
        logic       is_sync;
        logic       uncor;
    } ts_byte_t;

    function automatic logic [7:0] mark_error(input logic [7:0] d, input logic en);
        return en ? (d | 8'h80) : d;
    endfunction

endpackage

// File: rtl/ts_pkt_tracker.sv
module ts_pkt_tracker
    import ts_fmt_pkg::*;
#(
    parameter int PKT_LEN = 188
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       take,
    input  logic [7:0] in_data,
    input  logic       in_start,
    input  logic       in_uncor,
    input  logic       inh_rs,
    input  logic       inh_tei,
    output ts_byte_t   rec
);
    localparam int IDX_W = $clog2(PKT_LEN);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(PKT_LEN - 1);
    localparam logic [IDX_W-1:0] HDR1 = IDX_W'(1);

    logic [IDX_W-1:0] idx_q, idx_nx;
    logic             uncor_q, uncor_nx, force_mark;

    always_comb begin
        if (in_start)
            idx_nx = '0;
        else if (idx_q == LAST)
            idx_nx = LAST;
        else
            idx_nx = idx_q + 1'b1;
        uncor_nx   = in_start ? in_uncor : uncor_q;
        force_mark = uncor_nx && (idx_nx == HDR1) && !inh_rs && !inh_tei;
        rec.data    = in_start ? SYNC_BYTE : mark_error(in_data, force_mark);
        rec.is_sync = in_start;
        rec.uncor   = uncor_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= LAST;
            uncor_q <= 1'b0;
        end else if (take) begin
            idx_q   <= idx_nx;
            uncor_q <= uncor_nx;
        end
    end

endmodule

// File: rtl/ts_par_stage.sv
module ts_par_stage
    import ts_fmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  ts_byte_t   rec,
    output logic [7:0] out_data,
    output logic       out_den,
    output logic       out_sync
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_data <= '0;
            out_den  <= 1'b0;
            out_sync <= 1'b0;
        end else if (load) begin
            out_data <= rec.data;
            out_den  <= 1'b1;
            out_sync <= rec.is_sync;
        end else begin
            out_den  <= 1'b0;
            out_sync <= 1'b0;
        end
    end

endmodule

// File: rtl/ts_ser_shift.sv
module ts_ser_shift
    import ts_fmt_pkg::*;
#(
    parameter int BIT_CYCLES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  ts_byte_t rec,
    output logic     busy,
    output logic     bit_out,
    output logic     bit_stb,
    output logic     sync_out,
    output logic     last_cyc
);
    localparam int SUB_W = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(BIT_CYCLES - 1);

    logic [7:0]       sh_q;
    logic [2:0]       bit_q;
    logic [SUB_W-1:0] sub_q;
    logic             busy_q, sync_q;

    assign busy     = busy_q;
    assign bit_out  = sh_q[7];
    assign bit_stb  = busy_q && (sub_q == '0);
    assign sync_out = busy_q && sync_q && (bit_q == 3'd0);
    assign last_cyc = busy_q && (bit_q == 3'd7) && (sub_q == SUB_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            bit_q  <= '0;
            sub_q  <= '0;
            busy_q <= 1'b0;
            sync_q <= 1'b0;
        end else if (load) begin
            sh_q   <= rec.data;
            bit_q  <= '0;
            sub_q  <= '0;
            busy_q <= 1'b1;
            sync_q <= rec.is_sync;
        end else if (busy_q) begin
            if (sub_q == SUB_LAST) begin
                sub_q <= '0;
                sh_q  <= {sh_q[6:0], 1'b0};
                bit_q <= bit_q + 3'd1;
                if (bit_q == 3'd7)
                    busy_q <= 1'b0;
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ts_out_fmt.sv
module ts_out_fmt
    import ts_fmt_pkg::*;
#(
    parameter int PKT_LEN    = 188,
    parameter int BIT_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ser_mode,
    input  logic       inh_rs,
    input  logic       inh_tei,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_start,
    input  logic       in_uncor,
    output logic [7:0] ts_data,
    output logic       ts_den,
    output logic       ts_clk_en,
    output logic       ts_sync,
    output logic       ts_uncor
);
    ts_byte_t   rec;
    logic       take;
    logic       ser_busy, ser_bit, ser_stb, ser_sync, ser_last;
    logic [7:0] par_data;
    logic       par_den, par_sync;
    logic       uncor_q;

    assign in_ready = !ser_busy || ser_last;
    assign take     = in_valid && in_ready;

    ts_pkt_tracker #(.PKT_LEN(PKT_LEN)) u_trk (
        .clk(clk), .rst(rst), .take(take),
        .in_data(in_data), .in_start(in_start), .in_uncor(in_uncor),
        .inh_rs(inh_rs), .inh_tei(inh_tei), .rec(rec)
    );

    ts_par_stage u_par (
        .clk(clk), .rst(rst), .load(take && !ser_mode), .rec(rec),
        .out_data(par_data), .out_den(par_den), .out_sync(par_sync)
    );

    ts_ser_shift #(.BIT_CYCLES(BIT_CYCLES)) u_ser (
        .clk(clk), .rst(rst), .load(take && ser_mode), .rec(rec),
        .busy(ser_busy), .bit_out(ser_bit), .bit_stb(ser_stb),
        .sync_out(ser_sync), .last_cyc(ser_last)
    );

    always_ff @(posedge clk) begin
        if (rst)
            uncor_q <= 1'b0;
        else if (take)
            uncor_q <= rec.uncor;
    end

    always_comb begin
        if (ser_busy) begin
            ts_data   = {7'd0, ser_bit};
            ts_den    = 1'b1;
            ts_clk_en = ser_stb;
            ts_sync   = ser_sync;
        end else begin
            ts_data   = par_data;
            ts_den    = par_den;
            ts_clk_en = par_den;
            ts_sync   = par_sync;
        end
    end

    assign ts_uncor = uncor_q;

endmodule

// File: rtl/ts_out_fmt_chk.sv
module ts_out_fmt_chk (
    input logic       clk,
    input logic       rst,
    input logic       ser_mode,
    input logic       in_valid,
    input logic       in_ready,
    input logic       in_start,
    input logic [7:0] ts_data,
    input logic       ts_den,
    input logic       ts_clk_en,
    input logic       ts_sync
);
    logic acc;
    assign acc = in_valid && in_ready;

    assert_par_present_R2: assert property (@(posedge clk) disable iff (rst)
        (acc && !ser_mode) |=> (ts_den && ts_clk_en));

    assert_sync_value_R3: assert property (@(posedge clk) disable iff (rst)
        (acc && !ser_mode && in_start) |=> (ts_sync && ts_data == 8'h47));

    assert_sync_in_den_R4: assert property (@(posedge clk) disable iff (rst)
        ts_sync |-> ts_den);

    assert_ser_start_R7: assert property (@(posedge clk) disable iff (rst)
        (acc && ser_mode) |=> (ts_den && ts_clk_en && ts_data[7:1] == 7'd0));

    assert_stb_needs_den_R8: assert property (@(posedge clk) disable iff (rst)
        ts_clk_en |-> ts_den);

    assert_ready_low_shifting_R10: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> (ts_den && ts_data[7:1] == 7'd0));

endmodule

bind ts_out_fmt ts_out_fmt_chk u_chk (
    .clk(clk), .rst(rst), .ser_mode(ser_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_start(in_start),
    .ts_data(ts_data), .ts_den(ts_den), .ts_clk_en(ts_clk_en), .ts_sync(ts_sync)
);

// File: tb/ts_out_fmt_test.sv
module ts_out_fmt_test;
    localparam int PKT_LEN = 188;
    localparam int BITC    = 2;

    logic       clk = 1'b0;
    logic       rst;
    logic       ser_mode, inh_rs, inh_tei, in_valid, in_start, in_uncor;
    logic [7:0] in_data;
    logic       in_ready, ts_den, ts_clk_en, ts_sync, ts_uncor;
    logic [7:0] ts_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    ts_out_fmt #(.PKT_LEN(PKT_LEN), .BIT_CYCLES(BITC)) uut (
        .clk(clk), .rst(rst), .ser_mode(ser_mode), .inh_rs(inh_rs), .inh_tei(inh_tei),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_start(in_start), .in_uncor(in_uncor), .ts_data(ts_data), .ts_den(ts_den),
        .ts_clk_en(ts_clk_en), .ts_sync(ts_sync), .ts_uncor(ts_uncor)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // R1: reset state
    task automatic t_reset();
        rst = 1'b1; ser_mode = 0; inh_rs = 0; inh_tei = 0;
        in_valid = 0; in_start = 0; in_uncor = 0; in_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ts_den == 0,    "R1 den",    ts_den, 0);
        chk(ts_clk_en == 0, "R1 clk_en", ts_clk_en, 0);
        chk(ts_sync == 0,   "R1 sync",   ts_sync, 0);
        chk(ts_uncor == 0,  "R1 uncor",  ts_uncor, 0);
        chk(in_ready == 1,  "R1 ready",  in_ready, 1);
    endtask

    // Parallel byte: called at a negedge, returns at the next negedge after checking
    task automatic par_byte(input logic [7:0] d, input bit st, input bit un,
                            input logic [7:0] exp_d, input string tag, input bit exp_un);
        chk(in_ready == 1, "R11 ready", in_ready, 1);
        in_valid = 1; in_data = d; in_start = st; in_uncor = un;
        @(negedge clk);
        in_valid = 0; in_start = 0;
        chk(ts_data == exp_d, tag, ts_data, exp_d);
        chk(ts_den && ts_clk_en, "R2 den/clk_en", {ts_den, ts_clk_en}, 3);
        chk(ts_sync == st, "R4 sync", ts_sync, st);
        chk(ts_uncor == exp_un, "R5 uncor", ts_uncor, exp_un);
    endtask

    // Whole parallel packet with two idle gaps inside it
    task automatic t_par_packet(input bit un, input bit ia, input bit ib, input bit inv);
        bit mark = un && !ia && !ib;
        ser_mode = 0; inh_rs = ia; inh_tei = ib;
        for (int i = 0; i < PKT_LEN; i++) begin
            logic [7:0] d, e;
            string tag;
            if (i == 0) begin
                d = inv ? 8'hB8 : 8'h47; e = 8'h47; tag = "R3 sync byte";
            end else begin
                d = 8'(i * 7 + 3);
                e = (i == 1 && mark) ? (d | 8'h80) : d;
                tag = (i == 1) ? "R6 header byte" : "R6 payload byte";
            end
            par_byte(d, i == 0, un, e, tag, un);
            if (i == 1 || i == 60) begin
                @(negedge clk);
                chk(ts_den == 0 && ts_clk_en == 0, "R2 gap idle", {ts_den, ts_clk_en}, 0);
                chk(ts_sync == 0, "R4 gap sync", ts_sync, 0);
                chk(ts_uncor == un, "R5 gap hold", ts_uncor, un);
            end
        end
        inh_rs = 0; inh_tei = 0;
    endtask

    // Serial byte: entered at a negedge with in_ready high; leaves at the final bit cycle
    task automatic ser_byte(input logic [7:0] d, input bit st, input bit un,
                            input logic [7:0] exp_d, input bit exp_un);
        in_valid = 1; in_data = d; in_start = st; in_uncor = un;
        for (int b = 0; b < 8; b++) begin
            for (int c = 0; c < BITC; c++) begin
                @(negedge clk);
                in_valid = 0; in_start = 0;
                chk(ts_data[0] == exp_d[3'(7 - b)], "R7 bit", ts_data[0], exp_d[3'(7 - b)]);
                chk(ts_data[7:1] == 7'd0 && ts_den, "R7 bus/den", {ts_den, ts_data[7:1]}, 8'h80);
                chk(ts_clk_en == (c == 0), "R8 clk_en", ts_clk_en, (c == 0));
                chk(ts_sync == (st && b == 0), "R9 sync", ts_sync, (st && b == 0));
                chk(in_ready == (b == 7 && c == BITC - 1), "R10 ready", in_ready,
                    (b == 7 && c == BITC - 1));
                chk(ts_uncor == exp_un, "R5 serial uncor", ts_uncor, exp_un);
            end
        end
    endtask

    task automatic t_serial();
        ser_mode = 1;
        ser_byte(8'hB8, 1, 1, 8'h47, 1);  // inverted start restored (R3)
        ser_byte(8'h0A, 0, 0, 8'h8A, 1);  // header byte marked (R6), back-to-back (R10)
        ser_byte(8'hA5, 0, 0, 8'hA5, 1);
        ser_byte(8'h3C, 0, 0, 8'h3C, 1);
        @(negedge clk);
        chk(ts_den == 0 && ts_clk_en == 0, "R8 idle after serial", {ts_den, ts_clk_en}, 0);
        chk(in_ready == 1, "R10 ready idle", in_ready, 1);
        ser_mode = 0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_par_packet(0, 0, 0, 0);  // clean packet
        t_par_packet(1, 0, 0, 1);  // flagged, inverted start, marking enabled
        t_par_packet(1, 1, 0, 0);  // flagged, inh_rs suppresses
        t_par_packet(1, 0, 1, 0);  // flagged, inh_tei suppresses
        t_par_packet(0, 0, 0, 0);  // flag clears on next packet
        t_serial();
        done = 1;
        summary();
    end

endmodule